// File: doc/BRIEF.md
# Interrupt-to-DMA Activation Router

This block stands between the request flags of the peripherals and a multi-channel DMA transfer engine. Each channel has a source select, an enable bit and an exclusive bit. A rising edge on the selected flag of an enabled channel leaves a pending request latched for that channel. The router presents one request at a time to the engine, and the lowest-numbered pending channel goes first. When the engine acknowledges a channel, the router drops that channel's pending bit.

The router also decides where each flag goes. If the highest-priority enabled channel that selects a flag is exclusive, the flag is consumed by DMA alone. The router hides it from the CPU and sends a one-cycle clear pulse back to the peripheral. If that channel is not exclusive, or no enabled channel selects the flag, the CPU sees the flag and the router never clears it. For the source types that clear only when their data register is accessed (conversion-done, transmit-empty and receive-full), the clear pulse follows an access-match input and not the channel start. When a source feeds several channels, only the start of the highest-priority one clears the flag. The others stay pending and are served later in priority order.

Top module: `dma_act_router`

## Requirements
- R1: While reset is applied, `dma_req`, `src_clr` and `cpu_irq` are all zero.
- R2: A channel becomes pending only on a low-to-high change of its selected flag while the channel is enabled. A flag that stays high does not make the channel pending again after its acknowledge.
- R3: `dma_req` has at most one bit set, and that bit is the lowest-numbered pending channel (channel 0 has the highest priority). A channel lower in priority that is still pending is requested on the cycle after the higher one is acknowledged.
- R4: An acknowledge on a requested channel clears its pending bit, and `dma_req` for it is low in the next cycle. An acknowledge on a channel that is not requested has no effect.
- R5: For a source that clears on start (bits 0 to 4 of the default access mask are 0), acknowledging its owning channel while that channel is exclusive raises `src_clr` for that source in the next cycle, for one cycle.
- R6: The owner of a source is the lowest-numbered enabled channel that selects it. An acknowledge of any other channel that selects the same source produces no clear pulse.
- R7: When the owner's exclusive bit is 0, the acknowledge produces no clear pulse, and `cpu_irq` for that source follows the flag one cycle later.
- R8: For a source that clears on access (sources 5, 6 and 7 by default), an acknowledge produces no clear pulse. `src_clr` rises one cycle after `dreg_hit` for that source while its owner is exclusive. A `dreg_hit` on a source with no exclusive owner is ignored.
- R9: A disabled channel neither becomes pending nor keeps a pending bit: `dma_req` for it is low one cycle after its enable is seen low. A flag that no enabled channel selects reaches `cpu_irq` one cycle later.
- R10: While the owner of a source is exclusive, `cpu_irq` for that source is held at 0 whatever the flag does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_flag | input | NUM_SRC | Peripheral request flags, level |
| dreg_hit | input | NUM_SRC | Transfer accessed the data register of this source |
| cfg_sel | input | NUM_CH*SEL_W | Source select per channel, channel c at bits [c*SEL_W +: SEL_W] |
| cfg_en | input | NUM_CH | Channel enable |
| cfg_excl | input | NUM_CH | Channel exclusive-DMA bit |
| dma_ack | input | NUM_CH | Engine started the requested channel |
| dma_req | output | NUM_CH | One-hot request to the transfer engine |
| src_clr | output | NUM_SRC | One-cycle flag-clear pulse to the peripheral |
| cpu_irq | output | NUM_SRC | Flags passed on to the CPU interrupt controller |

## Verification
A wrong pending bit shows on `dma_req` on the very next cycle if it belongs to the top pending channel. Otherwise it shows only after every higher channel has been acknowledged, so the stress phase drains queues of up to four channels. A wrong owner or exclusive decision shows on `cpu_irq` one cycle after the flag moves, and on `src_clr` one cycle after the acknowledge or the access match. The bench therefore compares all three outputs against a reference model on every cycle, and it also runs directed sequences that hit each ordering case.

// File: rtl/dar_pkg.sv
package dar_pkg;

  // How a source's flag is cleared once DMA owns it.
  typedef enum logic {
    CLR_AT_START  = 1'b0,
    CLR_AT_ACCESS = 1'b1
  } clr_mode_e;

  function automatic clr_mode_e mode_of(input logic access_bit);
    return access_bit ? CLR_AT_ACCESS : CLR_AT_START;
  endfunction

endpackage

// File: rtl/dar_rst_sync.sv
module dar_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dar_owner_map.sv
// For every source: which enabled channel owns it (lowest index wins)
// and whether that owner takes it exclusively.
module dar_owner_map #(
  parameter int NUM_CH  = 4,
  parameter int NUM_SRC = 8,
  parameter int SEL_W   = 3
) (
  input  logic [NUM_CH*SEL_W-1:0]          cfg_sel,
  input  logic [NUM_CH-1:0]                cfg_en,
  input  logic [NUM_CH-1:0]                cfg_excl,
  output logic [NUM_SRC-1:0][NUM_CH-1:0]   owner_oh,
  output logic [NUM_SRC-1:0]               dma_excl
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [NUM_CH-1:0] hit;
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign hit[c] = cfg_en[c] && (cfg_sel[c*SEL_W +: SEL_W] == SEL_W'(s));
    end
    assign owner_oh[s] = hit & ~(hit - NUM_CH'(1));
    assign dma_excl[s] = |(owner_oh[s] & cfg_excl);
  end
endmodule

// File: rtl/dar_pend_chan.sv
// One channel's pending latch: set by an edge of its source, dropped by
// acknowledge or by disabling the channel. A new edge beats an acknowledge.
module dar_pend_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rise,
  input  logic ack_ok,
  output logic pend
);
  logic pend_q;
  logic pend_d;
  logic pend_ce;

  always_comb begin
    pend_ce = rise | ack_ok | ~en;
    pend_d  = en & (rise | (pend_q & ~ack_ok));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_ce) pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/dar_prio_grant.sv
// Fixed priority: bit 0 first.
module dar_prio_grant #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] pend,
  input  logic [NUM_CH-1:0] ack,
  output logic [NUM_CH-1:0] req,
  output logic [NUM_CH-1:0] ack_ok
);
  always_comb begin
    req    = pend & ~(pend - NUM_CH'(1));
    ack_ok = ack & req;
  end
endmodule

// File: rtl/dma_act_router.sv
module dma_act_router #(
  parameter int                 NUM_CH          = 4,
  parameter int                 NUM_SRC         = 8,
  parameter logic [NUM_SRC-1:0] ACCESS_CLR_MASK = 'hE0
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic [NUM_SRC-1:0]                            src_flag,
  input  logic [NUM_SRC-1:0]                            dreg_hit,
  input  logic [NUM_CH*((NUM_SRC>1)?$clog2(NUM_SRC):1)-1:0] cfg_sel,
  input  logic [NUM_CH-1:0]                             cfg_en,
  input  logic [NUM_CH-1:0]                             cfg_excl,
  input  logic [NUM_CH-1:0]                             dma_ack,
  output logic [NUM_CH-1:0]                             dma_req,
  output logic [NUM_SRC-1:0]                            src_clr,
  output logic [NUM_SRC-1:0]                            cpu_irq
);
  import dar_pkg::*;

  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic                             rst_sync_n;
  logic [NUM_SRC-1:0]               flag_q;
  logic [NUM_SRC-1:0]               rise;
  logic [NUM_CH-1:0]                rise_sel;
  logic [NUM_CH-1:0]                pend;
  logic [NUM_CH-1:0]                ack_ok;
  logic [NUM_SRC-1:0][NUM_CH-1:0]   owner_oh;
  logic [NUM_SRC-1:0]               dma_excl;
  logic [NUM_SRC-1:0]               clr_d;
  logic [NUM_SRC-1:0]               clr_q;
  logic [NUM_SRC-1:0]               cpu_d;
  logic [NUM_SRC-1:0]               cpu_q;

  dar_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Edge detection on the request flags.
  always_comb rise = src_flag & ~flag_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) flag_q <= '0;
    else             flag_q <= src_flag;
  end

  dar_owner_map #(
    .NUM_CH  (NUM_CH),
    .NUM_SRC (NUM_SRC),
    .SEL_W   (SEL_W)
  ) u_owner (
    .cfg_sel  (cfg_sel),
    .cfg_en   (cfg_en),
    .cfg_excl (cfg_excl),
    .owner_oh (owner_oh),
    .dma_excl (dma_excl)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign rise_sel[c] = rise[cfg_sel[c*SEL_W +: SEL_W]];

    dar_pend_chan u_pend (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .en     (cfg_en[c]),
      .rise   (rise_sel[c]),
      .ack_ok (ack_ok[c]),
      .pend   (pend[c])
    );
  end

  dar_prio_grant #(
    .NUM_CH (NUM_CH)
  ) u_grant (
    .pend   (pend),
    .ack    (dma_ack),
    .req    (dma_req),
    .ack_ok (ack_ok)
  );

  // Clear pulse per source, chosen by the source's clear mode.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_clr
    logic start_hit;
    assign start_hit = |(owner_oh[s] & ack_ok & cfg_excl);

    always_comb begin
      unique case (mode_of(ACCESS_CLR_MASK[s]))
        CLR_AT_ACCESS: clr_d[s] = dreg_hit[s] & dma_excl[s];
        default:       clr_d[s] = start_hit;
      endcase
    end
  end

  // CPU sees a flag unless an exclusive owner consumes it.
  always_comb cpu_d = src_flag & ~dma_excl;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      clr_q <= '0;
      cpu_q <= '0;
    end else begin
      clr_q <= clr_d;
      cpu_q <= cpu_d;
    end
  end

  assign src_clr = clr_q;
  assign cpu_irq = cpu_q;

endmodule

// File: rtl/dar_router_chk.sv
module dar_router_chk #(
  parameter int                 NUM_CH          = 4,
  parameter int                 NUM_SRC         = 8,
  parameter logic [NUM_SRC-1:0] ACCESS_CLR_MASK = 'hE0
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic [NUM_CH-1:0]  cfg_en,
  input logic [NUM_CH-1:0]  dma_req,
  input logic [NUM_CH-1:0]  dma_ack,
  input logic [NUM_SRC-1:0] src_clr,
  input logic [NUM_SRC-1:0] cpu_irq,
  input logic [NUM_SRC-1:0] dreg_hit,
  input logic [NUM_SRC-1:0] dma_excl
);
  // R3: one request at most toward the engine
  p_req_onehot_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(dma_req));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R9: a disabled channel has no request next cycle
    p_dis_no_req_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !cfg_en[c] |=> !dma_req[c]);
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    // R10: exclusive ownership masks the CPU line next cycle
    p_cpu_masked_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
      dma_excl[s] |=> !cpu_irq[s]);

    if (ACCESS_CLR_MASK[s]) begin : g_acc
      // R8: access-cleared sources pulse only after an access match
      p_clr_after_hit_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
        src_clr[s] |-> $past(dreg_hit[s]));
    end else begin : g_start
      // R5: start-cleared sources pulse only after an accepted acknowledge
      p_clr_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
        src_clr[s] |-> $past(|(dma_req & dma_ack)));
    end
  end
endmodule

bind dma_act_router dar_router_chk #(
  .NUM_CH          (NUM_CH),
  .NUM_SRC         (NUM_SRC),
  .ACCESS_CLR_MASK (ACCESS_CLR_MASK)
) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cfg_en     (cfg_en),
  .dma_req    (dma_req),
  .dma_ack    (dma_ack),
  .src_clr    (src_clr),
  .cpu_irq    (cpu_irq),
  .dreg_hit   (dreg_hit),
  .dma_excl   (dma_excl)
);

// File: tb/dma_act_router_tb_top.sv
module dma_act_router_tb_top;
  localparam int NCH = 4;
  localparam int NSRC = 8;
  localparam int SW = 3;
  localparam logic [NSRC-1:0] ACC = 8'hE0;

  logic              clk;
  logic              rst_n;
  logic [NSRC-1:0]   src_flag;
  logic [NSRC-1:0]   dreg_hit;
  logic [NCH*SW-1:0] cfg_sel;
  logic [NCH-1:0]    cfg_en;
  logic [NCH-1:0]    cfg_excl;
  logic [NCH-1:0]    dma_ack;
  logic [NCH-1:0]    dma_req;
  logic [NSRC-1:0]   src_clr;
  logic [NSRC-1:0]   cpu_irq;

  int n_chk;
  int n_fail;

  dma_act_router #(.NUM_CH(NCH), .NUM_SRC(NSRC), .ACCESS_CLR_MASK(ACC)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .dreg_hit(dreg_hit),
    .cfg_sel(cfg_sel), .cfg_en(cfg_en), .cfg_excl(cfg_excl), .dma_ack(dma_ack),
    .dma_req(dma_req), .src_clr(src_clr), .cpu_irq(cpu_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- reference model ----------------
  bit [NCH-1:0]  m_pend;
  bit [NSRC-1:0] m_fprev, m_clr, m_cpu;
  bit            m_s1, m_s2;

  function automatic bit [NCH-1:0] first_of(input bit [NCH-1:0] v);
    bit [NCH-1:0] r = '0;
    for (int i = 0; i < NCH; i++) if (v[i]) begin r[i] = 1'b1; break; end
    return r;
  endfunction

  always @(posedge clk) begin
    int own [NSRC];
    bit [NCH-1:0] req, ackok;
    bit act;
    act = m_s2;
    if (!act) begin
      m_pend = '0; m_fprev = '0; m_clr = '0; m_cpu = '0;
    end else begin
      for (int s = 0; s < NSRC; s++) own[s] = -1;
      for (int c = NCH - 1; c >= 0; c--)
        if (cfg_en[c]) own[int'(cfg_sel[c*SW +: SW])] = c;
      req = first_of(m_pend);
      ackok = dma_ack & req;
      for (int s = 0; s < NSRC; s++) begin
        bit ex;
        ex = (own[s] >= 0) && cfg_excl[own[s]];
        m_clr[s] = 1'b0;
        if (ex) m_clr[s] = ACC[s] ? dreg_hit[s] : ackok[own[s]];
        m_cpu[s] = src_flag[s] && !ex;
      end
      for (int c = 0; c < NCH; c++) begin
        bit r;
        r = src_flag[cfg_sel[c*SW +: SW]] && !m_fprev[cfg_sel[c*SW +: SW]];
        m_pend[c] = cfg_en[c] && (r || (m_pend[c] && !ackok[c]));
      end
      m_fprev = src_flag;
    end
    if (!rst_n) begin m_s1 = 1'b0; m_s2 = 1'b0; end
    else begin m_s2 = m_s1; m_s1 = 1'b1; end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison with the model
  always @(negedge clk) begin
    check("R3 dma_req vs model", 32'(dma_req), 32'(first_of(m_pend)));
    check("R5 src_clr vs model", 32'(src_clr), 32'(m_clr));
    check("R7 cpu_irq vs model", 32'(cpu_irq), 32'(m_cpu));
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(); @(negedge clk); endtask

  task automatic set_ch(input int c, input int sel, input bit en, input bit ex);
    cfg_sel[c*SW +: SW] = SW'(sel);
    cfg_en[c] = en;
    cfg_excl[c] = ex;
  endtask

  task automatic clear_all();
    src_flag = '0; dreg_hit = '0; dma_ack = '0;
    cfg_sel = '0; cfg_en = '0; cfg_excl = '0;
    tick(); tick();
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0;
    src_flag = '0; dreg_hit = '0; dma_ack = '0;
    cfg_sel = '0; cfg_en = '1; cfg_excl = '1;
    tick(); tick();
    src_flag = 8'hFF;  // activity during reset must not reach outputs
    tick();
    check("R1 req in reset", 32'(dma_req), 0);
    check("R1 clr in reset", 32'(src_clr), 0);
    check("R1 cpu in reset", 32'(cpu_irq), 0);
    src_flag = '0;
    rst_n = 1'b1;
    repeat (4) tick();
    clear_all();

    // R2 / R4 / R5 / R10 : single exclusive channel
    set_ch(0, 2, 1'b1, 1'b1); tick();
    src_flag[2] = 1'b1; tick();
    check("R2 pend on edge", 32'(dma_req), 32'h1);
    check("R10 cpu masked", 32'(cpu_irq), 0);
    dma_ack = 4'b0001; tick();
    check("R4 req dropped", 32'(dma_req), 0);
    check("R5 clr pulse", 32'(src_clr), 32'h04);
    dma_ack = '0; tick();
    check("R5 clr one cycle", 32'(src_clr), 0);
    check("R2 held level no repend", 32'(dma_req), 0);
    dma_ack = 4'b0010; tick();
    dma_ack = '0; tick();
    check("R4 stray ack no clr", 32'(src_clr), 0);
    check("R4 stray ack no req", 32'(dma_req), 0);
    clear_all();

    // R3 / R6 : shared source, channels 1 and 3
    set_ch(1, 4, 1'b1, 1'b1); set_ch(3, 4, 1'b1, 1'b1); tick();
    src_flag[4] = 1'b1; tick();
    check("R3 top channel first", 32'(dma_req), 32'h2);
    dma_ack = 4'b0010; tick();
    check("R3 next channel", 32'(dma_req), 32'h8);
    check("R6 owner clears", 32'(src_clr), 32'h10);
    dma_ack = 4'b1000; tick();
    check("R6 non-owner no clr", 32'(src_clr), 0);
    check("R4 queue drained", 32'(dma_req), 0);
    clear_all();

    // R7 : shared with CPU
    set_ch(2, 1, 1'b1, 1'b0); tick();
    src_flag[1] = 1'b1; tick();
    check("R7 cpu sees flag", 32'(cpu_irq), 32'h02);
    check("R7 req also", 32'(dma_req), 32'h4);
    dma_ack = 4'b0100; tick();
    check("R7 no clr", 32'(src_clr), 0);
    dma_ack = '0; src_flag[1] = 1'b0; tick();
    check("R7 cpu follows low", 32'(cpu_irq), 0);
    clear_all();

    // R8 : access-cleared source
    set_ch(0, 6, 1'b1, 1'b1); tick();
    src_flag[6] = 1'b1; tick();
    check("R8 req", 32'(dma_req), 32'h1);
    dma_ack = 4'b0001; tick();
    check("R8 no clr on ack", 32'(src_clr), 0);
    dma_ack = '0; dreg_hit = 8'h44; tick();
    check("R8 clr on access", 32'(src_clr), 32'h40);
    dreg_hit = '0; tick();
    check("R8 clr ends", 32'(src_clr), 0);
    clear_all();

    // R9 / R10 : disabled channel
    set_ch(0, 3, 1'b0, 1'b1); tick();
    src_flag[3] = 1'b1; tick();
    check("R9 no req when off", 32'(dma_req), 0);
    check("R9 cpu gets flag", 32'(cpu_irq), 32'h08);
    src_flag[3] = 1'b0; tick();
    set_ch(0, 3, 1'b1, 1'b1); src_flag[3] = 1'b1; tick();
    check("R9 req when on", 32'(dma_req), 32'h1);
    check("R10 cpu masked when owned", 32'(cpu_irq), 0);
    set_ch(0, 3, 1'b0, 1'b1); tick();
    check("R9 pend dropped", 32'(dma_req), 0);
    check("R9 cpu back", 32'(cpu_irq), 32'h08);
    clear_all();

    // stress against the model (R2 R3 R4 R5 R6 R7 R8 R9 R10)
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r0, r1, r2, r3;
      r0 = $urandom; r1 = $urandom; r2 = $urandom; r3 = $urandom;
      if (i % 60 == 0) begin
        cfg_sel  = r0[NCH*SW-1:0];
        cfg_en   = r1[NCH-1:0] | r1[7:4];
        cfg_excl = r1[11:8];
      end
      src_flag = src_flag ^ (r2[7:0] & r2[15:8] & r2[23:16]);
      dma_ack  = r3[3:0];
      dreg_hit = r3[15:8] & r3[23:16];
      tick();
    end
    clear_all();

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule